// File: doc/BRIEF.md
# Programmable SYSREF Pulse Generator

This block produces the SYSREF timing reference that a deterministic-latency serial converter link (subclass 1) needs. It runs from the device clock, so the reference is aligned with that clock. Its settings come from one 32-bit control word. A two-bit kind field selects one of three behaviours:

- a single pulse fired by software,
- a continuous square-ish wave,
- a continuous wave with a programmable high time.

The period is sixteen clocks times the link's frame-group count `e_param`, times a 5-bit multiplier.

The kind, the multiplier, the high-time count and `e_param` are sampled on every clock while `rst_n` is low. They are frozen from the first clock with `rst_n` high, and the effective period is reported on `period_o`. Two bits stay live after reset release: the polarity bit and the manual trigger bit.

In single-pulse mode a small state machine tracks the trigger bit. Its states are IDLE, ARMED and FIRE, with these transitions:

| Transition | Condition |
|---|---|
| IDLE→ARMED | the trigger is seen high while in single-pulse mode |
| ARMED→ARMED | the trigger stays high |
| ARMED→FIRE | the trigger is seen low |
| FIRE→IDLE | after 16 clocks in FIRE |

While in FIRE the trigger is not looked at.

Top module: `sref_pulse_gen`

## Requirements
- R1: `period_o` equals e×m×16 clocks, where e is `e_param` and m is the multiplier in control bits [6:2], whenever 1 ≤ e×m ≤ 16. The largest such period is 256.
- R2: When e×m is 0 or above 16, the multiplier used is 1. This includes a multiplier of 0. The period becomes e×16.
- R3: An `e_param` of 0 is treated as 1.
- R4: Control bits [1:0] select the kind: 2'b00 single pulse, 2'b01 periodic, 2'b10 gapped periodic. The code 2'b11 behaves exactly as periodic.
- R5: In the continuous kinds, a phase counter runs from 0 to period−1 and then wraps, starting from 0 at the first clock edge with `rst_n` high. `sysref_o` (before polarity) is high in the cycle after each edge at which the counter is below the high time. In periodic kind the high time is period/2.
- R6: In gapped kind, a high-time count in bits [15:8] from 1 to period−1 sets the number of high cycles per period.
- R7: In gapped kind, a high-time count of 0, or one ≥ the period, gives a high time of period/2.
- R8: The kind, the multiplier, the high-time count and `e_param` are captured on each clock edge with `rst_n` low. Later changes have no effect until the next reset.
- R9: Bit [16] is live: `sysref_o` is the generated level XOR bit [16]. During reset the output sits at bit [16].
- R10: In single-pulse kind, bit [17] sampled high and later sampled low at edge t makes `sysref_o` active for exactly 16 cycles, after edges t+1 to t+16.
- R11: A trigger that stays high gives no pulse. Trigger activity during a pulse is ignored. The trigger has no effect in the continuous kinds.
- R12: Bit [7] and bits [31:18] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low synchronous link reset; configuration is captured while low |
| ctrl_word | input | 32 | Control word: kind [1:0], multiplier [6:2], high time [15:8], polarity [16], trigger [17] |
| e_param | input | E_W | Frame-group count e of the link |
| sysref_o | output | 1 | Generated SYSREF level |
| period_o | output | E_W+4 | Effective period in clocks |

## Verification
The bench drives the limit products 16 and 17, a multiplier of 0 and an e of 0. A design that skips the fallback would report periods of 0 or above 256 and run a counter that never wraps correctly.

In gapped kind it tries high-time values of 0, period−1 and above the period. A missing clamp would give an output stuck high or stuck low.

Some control fields are changed after reset release. A design that fails to freeze them would shift the wave in mid-run.

The single-pulse cases cover three things:
- a trigger held high, where a level-sensitive design would fire early;
- a trigger toggled during a pulse, where a design that re-arms would stretch or repeat the pulse;
- trigger toggles in the continuous kinds, where a design with a shared counter would disturb the wave.

// File: rtl/sref_pkg.sv
package sref_pkg;

    typedef enum logic [1:0] {
        SREF_ONESHOT  = 2'b00,
        SREF_PERIODIC = 2'b01,
        SREF_GAPPED   = 2'b10,
        SREF_PER_ALT  = 2'b11
    } sref_kind_e;

    typedef enum logic [1:0] {
        OS_IDLE  = 2'b00,
        OS_ARMED = 2'b01,
        OS_FIRE  = 2'b10
    } os_state_e;

    // Field positions inside the control word
    localparam int KIND_LSB  = 0;
    localparam int MULT_LSB  = 2;
    localparam int MULT_W    = 5;
    localparam int DUTY_LSB  = 8;
    localparam int DUTY_W    = 8;
    localparam int PHASE_BIT = 16;
    localparam int TRIG_BIT  = 17;
    localparam int MAX_PROD  = 16;

endpackage

// File: rtl/sref_cfg_capture.sv
module sref_cfg_capture
    import sref_pkg::*;
#(
    parameter int E_W   = 5,
    parameter int PER_W = E_W + 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           kind_in,
    input  logic [MULT_W-1:0]    mult_in,
    input  logic [DUTY_W-1:0]    duty_in,
    input  logic [E_W-1:0]       e_in,
    output sref_kind_e           kind_q,
    output logic [PER_W-1:0]     period_q,
    output logic [PER_W-1:0]     high_q
);
    localparam int PROD_W = E_W + MULT_W;

    logic [E_W-1:0]    e_eff;
    logic [PROD_W-1:0] prod_raw;
    logic              prod_legal;
    logic [PROD_W-1:0] prod_eff;
    logic [PER_W-1:0]  per_calc;
    logic [PER_W-1:0]  half_calc;
    logic [PER_W-1:0]  duty_ext;
    logic [PER_W-1:0]  high_calc;
    sref_kind_e        kind_calc;

    always_comb begin
        e_eff      = (e_in == '0) ? E_W'(1) : e_in;
        prod_raw   = PROD_W'(e_eff) * PROD_W'(mult_in);
        prod_legal = (prod_raw != '0) && (prod_raw <= PROD_W'(MAX_PROD));
        prod_eff   = prod_legal ? prod_raw : PROD_W'(e_eff);
        per_calc   = {prod_eff[PER_W-5:0], 4'b0000};
        half_calc  = per_calc >> 1;
        duty_ext   = PER_W'(duty_in);
        kind_calc  = sref_kind_e'(kind_in);
        if (kind_calc == SREF_GAPPED && duty_in != '0 && duty_ext < per_calc)
            high_calc = duty_ext;
        else
            high_calc = half_calc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q   <= kind_calc;
            period_q <= per_calc;
            high_q   <= high_calc;
        end
    end

    // R6
    high_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (high_q != '0) && (high_q < period_q));

    // R8
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(period_q) && $stable(high_q) && $stable(kind_q)));

endmodule

// File: rtl/sref_period_gen.sv
module sref_period_gen #(
    parameter int PER_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period,
    input  logic [PER_W-1:0] high,
    output logic             active
);
    logic [PER_W-1:0] phase_q;
    logic             at_end;

    assign at_end = (phase_q == period - PER_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (at_end)
            phase_q <= '0;
        else
            phase_q <= phase_q + PER_W'(1);
    end

    assign active = (phase_q < high);

    // R5
    phase_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q < period);

    // R5
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == period - PER_W'(1)) |=> (phase_q == '0));

endmodule

// File: rtl/sref_oneshot_fsm.sv
module sref_oneshot_fsm
    import sref_pkg::*;
#(
    parameter int PULSE_LEN = 16,
    parameter int CNT_W     = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic trig,
    output logic fire
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_LEN - 1);

    os_state_e        state_q, state_d;
    logic [CNT_W-1:0] len_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_IDLE:  if (enable && trig) state_d = OS_ARMED;
            OS_ARMED: if (!trig)          state_d = OS_FIRE;
            OS_FIRE:  if (len_q == LAST)  state_d = OS_IDLE;
            default:                      state_d = OS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= OS_IDLE;
        else
            state_q <= state_d;
    end

    // pulse length counter
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != OS_FIRE)
            len_q <= '0;
        else
            len_q <= len_q + CNT_W'(1);
    end

    // outputs
    always_comb begin
        fire = (state_q == OS_FIRE);
    end

    // R10
    fire_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OS_FIRE && $past(state_q) != OS_FIRE) |-> ($past(state_q) == OS_ARMED && !$past(trig)));

    // R10
    fire_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OS_FIRE && len_q == LAST) |=> (state_q == OS_IDLE));

    // R11
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (state_q == OS_IDLE));

endmodule

// File: rtl/sref_pulse_gen.sv
module sref_pulse_gen
    import sref_pkg::*;
#(
    parameter int E_W       = 5,
    parameter int PULSE_LEN = 16,
    localparam int PER_W    = ((E_W > 5) ? E_W : 5) + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      ctrl_word,
    input  logic [E_W-1:0]   e_param,
    output logic             sysref_o,
    output logic [PER_W-1:0] period_o
);
    sref_kind_e       kind_q;
    logic [PER_W-1:0] high_q;
    logic             per_active;
    logic             os_fire;
    logic             is_oneshot;
    logic             phase_bit;
    logic             level;
    logic             unused_bits;

    assign unused_bits = ^{ctrl_word[31:18], ctrl_word[7]};
    assign phase_bit   = ctrl_word[PHASE_BIT];

    sref_cfg_capture #(.E_W(E_W), .PER_W(PER_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind_in  (ctrl_word[KIND_LSB +: 2]),
        .mult_in  (ctrl_word[MULT_LSB +: MULT_W]),
        .duty_in  (ctrl_word[DUTY_LSB +: DUTY_W]),
        .e_in     (e_param),
        .kind_q   (kind_q),
        .period_q (period_o),
        .high_q   (high_q)
    );

    sref_period_gen #(.PER_W(PER_W)) u_per (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (period_o),
        .high   (high_q),
        .active (per_active)
    );

    assign is_oneshot = (kind_q == SREF_ONESHOT);

    sref_oneshot_fsm #(.PULSE_LEN(PULSE_LEN)) u_os (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (is_oneshot),
        .trig   (ctrl_word[TRIG_BIT]),
        .fire   (os_fire)
    );

    always_comb begin
        level = is_oneshot ? os_fire : per_active;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            sysref_o <= phase_bit;
        else
            sysref_o <= level ^ phase_bit;
    end

    // R1
    period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_o >= PER_W'(16)) && (period_o[3:0] == 4'd0));

endmodule

// File: tb/sref_pulse_gen_tb.sv
module sref_pulse_gen_tb;
    localparam int E_W = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic [4:0]  e_param = 5'd1;
    logic        sysref_o;
    logic [8:0]  period_o;

    int compared = 0;
    int mismatched = 0;
    string cur_req = "R9";
    string per_req = "R1";

    // model state
    int m_kind, m_period, m_high, m_j, m_os, m_k;
    bit exp_out;
    bit seen_edge = 0;

    always #10 clk = ~clk;

    sref_pulse_gen #(.E_W(E_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .e_param(e_param),
        .sysref_o(sysref_o), .period_o(period_o)
    );

    function automatic logic [31:0] mk(input int kind, input int mult, input int duty,
                                       input bit ph, input bit trig, input logic [13:0] rsv);
        return {rsv, trig, ph, 8'(duty), 1'b0, 5'(mult), 2'(kind)};
    endfunction

    // behavioural reference model
    always @(posedge clk) begin
        bit ph, act;
        int e, m, d;
        ph = ctrl_word[16];
        if (!rst_n) begin
            e = (e_param == 0) ? 1 : int'(e_param);
            m = int'(ctrl_word[6:2]);
            if (e * m < 1 || e * m > 16) m = 1;
            m_period = e * m * 16;
            m_kind = int'(ctrl_word[1:0]);
            d = int'(ctrl_word[15:8]);
            if (m_kind == 2 && d != 0 && d < m_period) m_high = d;
            else m_high = m_period / 2;
            m_j = 0; m_os = 0; m_k = 0;
            exp_out = ph;
        end else begin
            if (m_kind == 0) begin
                act = (m_os == 2);
                case (m_os)
                    0: if (ctrl_word[17]) m_os = 1;
                    1: if (!ctrl_word[17]) begin m_os = 2; m_k = 0; end
                    default: begin m_k++; if (m_k == 16) m_os = 0; end
                endcase
            end else begin
                act = (m_j < m_high);
                m_j = (m_j + 1) % m_period;
            end
            exp_out = act ^ ph;
        end
        seen_edge = 1;
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (seen_edge) begin
            compared++;
            if (sysref_o !== exp_out) begin
                mismatched++;
                $display("FAIL %s sysref_o actual=%0b expected=%0b at %0t", cur_req, sysref_o, exp_out, $time);
            end
            compared++;
            if (period_o !== 9'(m_period)) begin
                mismatched++;
                $display("FAIL %s period_o actual=%0d expected=%0d at %0t", per_req, period_o, m_period, $time);
            end
        end
    end

    task automatic at_drive();
        @(posedge clk); #5;
    endtask

    task automatic run_cfg(input logic [31:0] w, input logic [4:0] e, input int run_cycles,
                           input string req, input string preq);
        at_drive();
        rst_n = 1'b0; ctrl_word = w; e_param = e; cur_req = req; per_req = preq;
        repeat (4) @(posedge clk);
        #5 rst_n = 1'b1;
        repeat (run_cycles) @(posedge clk);
    endtask

    task automatic set_ctrl(input logic [31:0] w, input int cycles);
        at_drive();
        ctrl_word = w;
        repeat (cycles) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        // R9 reset level with polarity low, then high
        repeat (3) @(posedge clk);
        set_ctrl(mk(1, 1, 0, 1, 0, 0), 3);

        // R1 R5 periodic e=1 m=1 -> 16, high 8
        run_cfg(mk(1, 1, 0, 0, 0, 0), 5'd1, 60, "R5", "R1");
        // R4 kind 11 as periodic, e=3 m=5 -> 240
        run_cfg(mk(3, 5, 77, 0, 0, 0), 5'd3, 520, "R4", "R1");
        // R2 illegal product 18 -> m=1, period 32; R6 gapped high 20
        run_cfg(mk(2, 9, 20, 0, 0, 0), 5'd2, 100, "R6", "R2");
        // R2 multiplier 0 -> period 16; R7 duty 0 -> 8
        run_cfg(mk(2, 0, 0, 0, 0, 0), 5'd1, 50, "R7", "R2");
        // R7 duty 40 >= period 32 -> 16
        run_cfg(mk(2, 2, 40, 0, 0, 0), 5'd1, 100, "R7", "R1");
        // R3 e=0 as 1, m=4 -> 64; R6 boundary duty 63
        run_cfg(mk(2, 4, 63, 0, 0, 0), 5'd0, 200, "R6", "R3");
        // R1 boundary product 16 -> 256; R6 duty 255
        run_cfg(mk(2, 1, 255, 0, 0, 0), 5'd16, 560, "R6", "R1");
        // R2 boundary product 17 -> fallback period 17*16? no: e=17 m=1 legal? 17>16 -> m=1, period 272
        run_cfg(mk(1, 1, 0, 0, 0, 0), 5'd17, 600, "R5", "R2");

        // R8 capture: change kind, mult, duty, e after release
        run_cfg(mk(2, 2, 5, 0, 0, 0), 5'd1, 40, "R8", "R8");
        set_ctrl(mk(0, 7, 200, 0, 0, 0), 30);
        at_drive(); e_param = 5'd4;
        repeat (40) @(posedge clk);
        // R12 reserved and select bits toggled
        cur_req = "R12";
        set_ctrl(mk(2, 2, 5, 0, 0, 14'h3fff) | 32'h80, 70);
        // R9 live polarity
        cur_req = "R9";
        set_ctrl(mk(2, 2, 5, 1, 0, 0), 70);
        set_ctrl(mk(2, 2, 5, 0, 0, 0), 20);
        // R11 trigger ignored in continuous kinds
        cur_req = "R11";
        for (int i = 0; i < 6; i++) begin
            set_ctrl(mk(2, 2, 5, 0, 1, 0), 3);
            set_ctrl(mk(2, 2, 5, 0, 0, 0), 4);
        end

        // R10 single pulse
        run_cfg(mk(0, 3, 9, 0, 0, 0), 5'd1, 10, "R10", "R1");
        set_ctrl(mk(0, 3, 9, 0, 1, 0), 3);
        set_ctrl(mk(0, 3, 9, 0, 0, 0), 30);
        // R10 with inverted polarity
        set_ctrl(mk(0, 3, 9, 1, 1, 0), 2);
        set_ctrl(mk(0, 3, 9, 1, 0, 0), 30);
        set_ctrl(mk(0, 3, 9, 0, 0, 0), 5);
        // R11 held high: no pulse
        cur_req = "R11";
        set_ctrl(mk(0, 3, 9, 0, 1, 0), 40);
        set_ctrl(mk(0, 3, 9, 0, 0, 0), 30);
        // R11 toggling during the pulse
        set_ctrl(mk(0, 3, 9, 0, 1, 0), 1);
        set_ctrl(mk(0, 3, 9, 0, 0, 0), 4);
        set_ctrl(mk(0, 3, 9, 0, 1, 0), 2);
        set_ctrl(mk(0, 3, 9, 0, 0, 0), 3);
        set_ctrl(mk(0, 3, 9, 0, 1, 0), 14);
        set_ctrl(mk(0, 3, 9, 0, 0, 0), 40);

        at_drive();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule